// File: doc/BRIEF.md
# Real-Time Clock Event Status Register

This block keeps the status and event flags of a real-time clock in a single 32-bit register. Pulses from the surrounding calendar logic set the flags. These pulses are alarm matches, time-stamp captures, tamper detections, wakeup expiry, shadow copies, shift start and finish, and calibration write and apply. Software reads the whole register through `rd_data`. Software clears event flags by writing 0 to them, and writing 1 to any flag leaves it as it was.

The register also holds an initialization request bit. While this bit is set, an initialization-active status bit rises after a fixed settling delay. Most writable bits are ignored unless the unlock input is high. Bits 13 to 8 form an open field that software can write at any time.

Each event flag is gated by its own enable bit, and the results are ORed into one interrupt line. The calendar counters, the alarm comparators and the key sequence that drives the unlock input are outside this block.

Top module: `rtc_evt_status`

## Requirements
- R1: After reset every register bit reads 0, so `rd_data` equals `year_nonzero` at bit 2 and is 0 elsewhere, and `irq` is 0.
- R2: The event flags are alarm A (bit 8), alarm B (bit 9), wakeup (bit 10), time-stamp (bit 11), internal time-stamp (bit 13) and tamper k (bit 16+k). Each reads 1 from the edge after its strobe. An allowed write with a 0 in its position clears it, and a 1 in its position leaves it unchanged.
- R3: When a set strobe and a clearing write hit the same flag in one cycle, the flag ends at 1.
- R4: The time-stamp overflow flag (bit 12) sets when a time-stamp strobe arrives while bit 11 already reads 1, and is cleared by writing 0. A time-stamp strobe while bit 11 reads 0 does not set it.
- R5: The shift-pending bit (bit 0) sets on `ev_shift_start` and clears on `ev_shift_done`, with start winning if both arrive together. Writes have no effect on it.
- R6: The sync bit (bit 1) sets on `ev_sync`. At an edge where the init-active bit or shift-pending bit reads 1, or `shadow_bypass` is 1, it becomes 0 regardless of the strobe. Otherwise an unlocked write of 0 clears it.
- R7: The recalibration-pending bit (bit 5) sets on `ev_cal_write` and clears on `ev_cal_applied`, with the write strobe winning. Writes have no effect on it.
- R8: Bit 2 reads the current value of `year_nonzero`.
- R9: The init request bit (bit 4) is written by unlocked writes. The init-active bit (bit 3) reads 1 from the INIT_DELAY-th edge after bit 4 first reads 1, and reads 0 at the same edge where bit 4 returns to 0.
- R10: While `wr_unlocked` is 0, a write changes only bits 13 to 8. Bits 1, 4 and 16 upward keep their values.
- R11: `irq` is 1 exactly when some event flag reads 1 and its enable is 1. Enable bits 0 to 5 map to bits 8 to 13, and enable bit 6+k maps to tamper k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_unlocked | input | 1 | High when protected bits may be written |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register read value |
| ev_alarm_a | input | 1 | Alarm A match pulse |
| ev_alarm_b | input | 1 | Alarm B match pulse |
| ev_wakeup | input | 1 | Wakeup counter expiry pulse |
| ev_tstamp | input | 1 | Time-stamp event pulse |
| ev_itstamp | input | 1 | Internal time-stamp event pulse |
| ev_tamper | input | NTAMP | Tamper detection pulses, one per input |
| ev_sync | input | 1 | Shadow copy done pulse |
| ev_shift_start | input | 1 | Shift register written pulse |
| ev_shift_done | input | 1 | Shift executed pulse |
| ev_cal_write | input | 1 | Calibration register written pulse |
| ev_cal_applied | input | 1 | New calibration in effect pulse |
| shadow_bypass | input | 1 | Shadow bypass mode level |
| year_nonzero | input | 1 | Calendar year field is non-zero |
| irq_en | input | NTAMP+6 | Per-flag interrupt enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with NTAMP = 3 and INIT_DELAY = 2. With three tamper inputs, the highest tamper flag (bit 18) and its enable (bit 8) are both reachable, so the edge of the event vector is exercised. A delay of two edges lets the bench watch the init-active bit stay low for exactly two cycles after the request and then drop in the same cycle the request is cleared. It also lets the bench confirm that the sync bit is held clear throughout that window.

// File: rtl/rtc_evt_pkg.sv
// Package rtc_evt_pkg
// Holds the bit positions of the status register and the bounds of the
// field that software may write without unlocking. Positions are fixed
// because software decodes them.
package rtc_evt_pkg;
    localparam int REG_W     = 32;
    localparam int B_SHIFT   = 0;
    localparam int B_SYNC    = 1;
    localparam int B_INITS   = 2;
    localparam int B_INITF   = 3;
    localparam int B_INITREQ = 4;
    localparam int B_RECAL   = 5;
    localparam int B_EVT0    = 8;   // six primary event flags at 8..13
    localparam int N_PRIM    = 6;
    localparam int B_TAMP    = 16;  // tamper flags from here upward
    localparam int OPEN_LO   = 8;
    localparam int OPEN_HI   = 13;

    // Register position of event index k (0..5 primary, 6.. tamper)
    function automatic int evt_pos(input int k);
        return (k < N_PRIM) ? (B_EVT0 + k) : (B_TAMP + k - N_PRIM);
    endfunction
endpackage

// File: rtl/rtc_w0c_flag.sv
// Module rtc_w0c_flag
// One flag bit that hardware sets and software clears by writing 0.
// Priority: hold_clr first, then the hardware set, then the software clear.
// Assumes wr_ok already includes write protection for this bit.
module rtc_w0c_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clr,
    input  logic set,
    input  logic wr_ok,
    input  logic wr_bit,
    output logic q
);
    // Update the flag with hold, set, and clear-by-zero priority
    always_ff @(posedge clk) begin
        if (!rst_n)                q <= 1'b0;
        else if (hold_clr)         q <= 1'b0;
        else if (set)              q <= 1'b1;
        else if (wr_ok && !wr_bit) q <= 1'b0;
    end
endmodule

// File: rtl/rtc_pend_flag.sv
// Module rtc_pend_flag
// A pending bit owned by hardware: it is raised by a start pulse and
// dropped by a done pulse. Start wins when both pulses arrive together.
// Software has no path into it.
module rtc_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    output logic q
);
    // Track the pending state between start and done
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= 1'b0;
        else if (start) q <= 1'b1;
        else if (done)  q <= 1'b0;
    end
endmodule

// File: rtl/rtc_init_seq.sv
// Module rtc_init_seq
// Holds the initialization request bit and reports init-active once the
// request has been held for DELAY edges. Active drops in the same cycle
// the request drops. Assumes DELAY >= 1 and that wr_ok already includes
// write protection.
module rtc_init_seq #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ok,
    input  logic wr_bit,
    output logic req,
    output logic active
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt;

    // Request bit written by software
    always_ff @(posedge clk) begin
        if (!rst_n)     req <= 1'b0;
        else if (wr_ok) req <= wr_bit;
    end

    // Settling counter that runs while the request is held
    always_ff @(posedge clk) begin
        if (!rst_n || !req)           cnt <= '0;
        else if (cnt != CW'(DELAY))   cnt <= cnt + 1'b1;
    end

    assign active = req && (cnt == CW'(DELAY));
endmodule

// File: rtl/rtc_evt_status.sv
// Module rtc_evt_status
// Status and event flag register of a real-time clock. Event pulses set
// flags. Software reads the register and clears flags by writing 0.
// Bits OPEN_LO..OPEN_HI accept writes at any time; other writable bits
// need wr_unlocked. Each event flag is ANDed with its enable and the
// results are ORed into irq. Assumes all ev_* inputs are one-cycle pulses
// in the clk domain.
module rtc_evt_status
    import rtc_evt_pkg::*;
#(
    parameter int NTAMP      = 3,
    parameter int INIT_DELAY = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_unlocked,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic                 ev_alarm_a,
    input  logic                 ev_alarm_b,
    input  logic                 ev_wakeup,
    input  logic                 ev_tstamp,
    input  logic                 ev_itstamp,
    input  logic [NTAMP-1:0]     ev_tamper,
    input  logic                 ev_sync,
    input  logic                 ev_shift_start,
    input  logic                 ev_shift_done,
    input  logic                 ev_cal_write,
    input  logic                 ev_cal_applied,
    input  logic                 shadow_bypass,
    input  logic                 year_nonzero,
    input  logic [NTAMP+5:0]     irq_en,
    output logic                 irq
);
    localparam int NEVT = N_PRIM + NTAMP;

    logic            wr_open;
    logic            wr_lock;
    logic [NEVT-1:0] evt_set;
    logic [NEVT-1:0] evt_q;
    logic            tsovf_set;
    logic            shift_q;
    logic            sync_q;
    logic            recal_q;
    logic            init_req;
    logic            init_act;
    logic            sync_hold;
    logic            unused_wr_bits;

    assign wr_open = wr_en;
    assign wr_lock = wr_en && wr_unlocked;

    // Overflow sets only when a time-stamp repeats with the flag still up
    assign tsovf_set = ev_tstamp && evt_q[3];
    assign evt_set   = {ev_tamper, ev_itstamp, tsovf_set, ev_tstamp,
                        ev_wakeup, ev_alarm_b, ev_alarm_a};

    // One clear-by-zero cell per event flag; the open field needs no unlock
    for (genvar k = 0; k < NEVT; k++) begin : g_evt
        localparam int POS = evt_pos(k);
        if (POS >= OPEN_LO && POS <= OPEN_HI) begin : g_open
            rtc_w0c_flag u_flag (
                .clk(clk), .rst_n(rst_n), .hold_clr(1'b0),
                .set(evt_set[k]), .wr_ok(wr_open),
                .wr_bit(wr_data[POS]), .q(evt_q[k])
            );
        end else begin : g_prot
            rtc_w0c_flag u_flag (
                .clk(clk), .rst_n(rst_n), .hold_clr(1'b0),
                .set(evt_set[k]), .wr_ok(wr_lock),
                .wr_bit(wr_data[POS]), .q(evt_q[k])
            );
        end
    end

    assign sync_hold = init_act || shift_q || shadow_bypass;

    rtc_w0c_flag u_sync (
        .clk(clk), .rst_n(rst_n), .hold_clr(sync_hold),
        .set(ev_sync), .wr_ok(wr_lock),
        .wr_bit(wr_data[B_SYNC]), .q(sync_q)
    );

    rtc_pend_flag u_shift (
        .clk(clk), .rst_n(rst_n), .start(ev_shift_start),
        .done(ev_shift_done), .q(shift_q)
    );

    rtc_pend_flag u_recal (
        .clk(clk), .rst_n(rst_n), .start(ev_cal_write),
        .done(ev_cal_applied), .q(recal_q)
    );

    rtc_init_seq #(.DELAY(INIT_DELAY)) u_init (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_lock),
        .wr_bit(wr_data[B_INITREQ]), .req(init_req), .active(init_act)
    );

    // Assemble the read view from all flag sources
    always_comb begin
        rd_data            = '0;
        rd_data[B_SHIFT]   = shift_q;
        rd_data[B_SYNC]    = sync_q;
        rd_data[B_INITS]   = year_nonzero;
        rd_data[B_INITF]   = init_act;
        rd_data[B_INITREQ] = init_req;
        rd_data[B_RECAL]   = recal_q;
        for (int k = 0; k < NEVT; k++) rd_data[evt_pos(k)] = evt_q[k];
    end

    assign irq = |(evt_q & irq_en);

    // Write data bits with no storage behind them are read into a sink
    assign unused_wr_bits = ^wr_data;
endmodule

// File: rtl/rtc_evt_status_chk.sv
// Module rtc_evt_status_chk
// Property checker bound to rtc_evt_status. It watches the event inputs,
// the write strobes and selected register bits, and checks their
// cycle-to-cycle relations.
module rtc_evt_status_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_unlocked,
    input logic ev_alarm_a,
    input logic ev_tstamp,
    input logic ev_sync,
    input logic ev_shift_start,
    input logic ev_shift_done,
    input logic ev_cal_write,
    input logic shadow_bypass,
    input logic shift_q,
    input logic sync_q,
    input logic initf_q,
    input logic initreq_q,
    input logic recal_q,
    input logic ala_q,
    input logic ts_q,
    input logic tsov_q
);
    assert_alarm_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_alarm_a |=> ala_q);

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tstamp && wr_en) |=> ts_q);

    assert_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tstamp && ts_q) |=> tsov_q);

    assert_shift_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_shift_start |=> shift_q);

    assert_shift_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_shift_done && !ev_shift_start) |=> !shift_q);

    assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (initf_q || shift_q || shadow_bypass) |=> !sync_q);

    assert_sync_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sync && !initf_q && !shift_q && !shadow_bypass) |=> sync_q);

    assert_recal_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cal_write |=> recal_q);

    assert_init_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        initf_q |-> initreq_q);

    assert_locked_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_unlocked) |=> $stable(initreq_q));
endmodule

bind rtc_evt_status rtc_evt_status_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_unlocked(wr_unlocked),
    .ev_alarm_a(ev_alarm_a), .ev_tstamp(ev_tstamp), .ev_sync(ev_sync),
    .ev_shift_start(ev_shift_start), .ev_shift_done(ev_shift_done),
    .ev_cal_write(ev_cal_write), .shadow_bypass(shadow_bypass),
    .shift_q(rd_data[rtc_evt_pkg::B_SHIFT]),
    .sync_q(rd_data[rtc_evt_pkg::B_SYNC]),
    .initf_q(rd_data[rtc_evt_pkg::B_INITF]),
    .initreq_q(rd_data[rtc_evt_pkg::B_INITREQ]),
    .recal_q(rd_data[rtc_evt_pkg::B_RECAL]),
    .ala_q(rd_data[rtc_evt_pkg::B_EVT0]),
    .ts_q(rd_data[rtc_evt_pkg::B_EVT0 + 3]),
    .tsov_q(rd_data[rtc_evt_pkg::B_EVT0 + 4])
);

// File: tb/rtc_evt_status_tb_top.sv
// Bench rtc_evt_status_tb_top
// Scoreboard bench. Driver tasks apply stimulus at the falling edge and
// push the expected register and irq values. A monitor pops them one
// time unit after the next rising edge and compares.
module rtc_evt_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NTAMP      = 3;
    localparam int INIT_DELAY = 2;
    localparam int NEVT       = NTAMP + 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic            wr_unlocked = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic            ev_alarm_a = 0, ev_alarm_b = 0, ev_wakeup = 0;
    logic            ev_tstamp = 0, ev_itstamp = 0, ev_sync = 0;
    logic [NTAMP-1:0] ev_tamper = '0;
    logic            ev_shift_start = 0, ev_shift_done = 0;
    logic            ev_cal_write = 0, ev_cal_applied = 0;
    logic            shadow_bypass = 0, year_nonzero = 0;
    logic [NEVT-1:0] irq_en = '0;
    logic            irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    string       q_req[$];
    logic [31:0] q_m[$];
    logic [31:0] q_e[$];
    bit          q_ci[$];
    bit          q_ei[$];

    rtc_evt_status #(.NTAMP(NTAMP), .INIT_DELAY(INIT_DELAY)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_unlocked(wr_unlocked),
        .wr_data(wr_data), .rd_data(rd_data), .ev_alarm_a(ev_alarm_a),
        .ev_alarm_b(ev_alarm_b), .ev_wakeup(ev_wakeup), .ev_tstamp(ev_tstamp),
        .ev_itstamp(ev_itstamp), .ev_tamper(ev_tamper), .ev_sync(ev_sync),
        .ev_shift_start(ev_shift_start), .ev_shift_done(ev_shift_done),
        .ev_cal_write(ev_cal_write), .ev_cal_applied(ev_cal_applied),
        .shadow_bypass(shadow_bypass), .year_nonzero(year_nonzero),
        .irq_en(irq_en), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Push the expectation for the coming edge, run one cycle, drop pulses
    task automatic tick(input string req, input logic [31:0] m,
                        input logic [31:0] e, input bit ci, input bit ei);
        if (m != 0 || ci) begin
            q_req.push_back(req); q_m.push_back(m); q_e.push_back(e);
            q_ci.push_back(ci);   q_ei.push_back(ei);
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; ev_alarm_a = 0; ev_alarm_b = 0; ev_wakeup = 0;
        ev_tstamp = 0; ev_itstamp = 0; ev_tamper = '0; ev_sync = 0;
        ev_shift_start = 0; ev_shift_done = 0;
        ev_cal_write = 0; ev_cal_applied = 0;
    endtask

    task automatic wr(input logic [31:0] d, input logic unl);
        wr_en = 1; wr_data = d; wr_unlocked = unl;
    endtask

    // Monitor: compare design outputs with the oldest expectation
    initial forever begin
        @(posedge clk);
        #1;
        if (q_m.size() > 0) begin
            string r; logic [31:0] m, e; bit ci, ei;
            r = q_req.pop_front(); m = q_m.pop_front(); e = q_e.pop_front();
            ci = q_ci.pop_front(); ei = q_ei.pop_front();
            if (m != 0) begin
                checks++;
                if ((rd_data & m) !== e) begin
                    errors++;
                    $display("FAIL %s rd_data&%h actual %h expected %h", r, m, rd_data & m, e);
                end
            end
            if (ci) begin
                checks++;
                if (irq !== ei) begin
                    errors++;
                    $display("FAIL %s irq actual %b expected %b", r, irq, ei);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick("R1", 32'hFFFF_FFFF, 32'h0, 1, 0);
        // R2 set on event
        ev_alarm_a = 1; ev_wakeup = 1;
        tick("R2", 32'h0000_0500, 32'h0000_0500, 0, 0);
        // R2 writing ones leaves flags, locked write keeps bit4
        wr(32'hFFFF_FFFF, 0);
        tick("R2", 32'h0000_0710, 32'h0000_0500, 0, 0);
        // R10 open field clears while locked
        wr(~32'h0000_0100, 0);
        tick("R10", 32'h0000_0510, 32'h0000_0400, 0, 0);
        // R3 set beats clear on alarm B
        wr(32'h0, 1); ev_alarm_b = 1;
        tick("R3", 32'h0000_0610, 32'h0000_0200, 0, 0);
        // R4 overflow sequence
        ev_tstamp = 1;
        tick("R4", 32'h0000_1800, 32'h0000_0800, 0, 0);
        ev_tstamp = 1;
        tick("R4", 32'h0000_1800, 32'h0000_1800, 0, 0);
        wr(~32'h0000_0800, 1);
        tick("R4", 32'h0000_1800, 32'h0000_1000, 0, 0);
        ev_tstamp = 1; wr(~32'h0000_1000, 0);
        tick("R4", 32'h0000_1800, 32'h0000_0800, 0, 0);
        ev_tstamp = 1; wr(~32'h0000_0800, 0);
        tick("R3", 32'h0000_1800, 32'h0000_1800, 0, 0);
        // R2 tamper and internal time-stamp
        ev_tamper = 3'b001; ev_itstamp = 1;
        tick("R2", 32'h0007_2000, 32'h0001_2000, 0, 0);
        wr(32'h0, 0);
        tick("R10", 32'h0001_3F00, 32'h0001_0000, 0, 0);
        wr(32'hFFFE_FFEF, 1);
        tick("R2", 32'h0001_0010, 32'h0, 0, 0);
        // R5 shift pending
        ev_shift_start = 1;
        tick("R5", 32'h1, 32'h1, 0, 0);
        wr(32'h0, 1);
        tick("R5", 32'h1, 32'h1, 0, 0);
        ev_sync = 1;
        tick("R6", 32'h3, 32'h1, 0, 0);
        ev_shift_done = 1;
        tick("R5", 32'h1, 32'h0, 0, 0);
        wr(32'hFFFF_FFEF, 1);
        tick("R5", 32'h1, 32'h0, 0, 0);
        // R6 sync flag
        ev_sync = 1;
        tick("R6", 32'h2, 32'h2, 0, 0);
        shadow_bypass = 1;
        tick("R6", 32'h2, 32'h0, 0, 0);
        ev_sync = 1;
        tick("R6", 32'h2, 32'h0, 0, 0);
        shadow_bypass = 0; ev_sync = 1;
        tick("R6", 32'h2, 32'h2, 0, 0);
        wr(32'h0, 0);
        tick("R10", 32'h2, 32'h2, 0, 0);
        wr(32'hFFFF_FFED, 1);
        tick("R6", 32'h2, 32'h0, 0, 0);
        // R7 recalibration pending
        ev_cal_write = 1;
        tick("R7", 32'h20, 32'h20, 0, 0);
        ev_cal_write = 1; ev_cal_applied = 1;
        tick("R7", 32'h20, 32'h20, 0, 0);
        ev_cal_applied = 1;
        tick("R7", 32'h20, 32'h0, 0, 0);
        // R8 year status
        year_nonzero = 1;
        tick("R8", 32'h4, 32'h4, 0, 0);
        year_nonzero = 0;
        tick("R8", 32'h4, 32'h0, 0, 0);
        // R10 locked write cannot set the init request
        wr(32'hFFFF_FFFF, 0);
        tick("R10", 32'h10, 32'h0, 0, 0);
        // R9 init request and delayed active
        wr(32'h10, 1);
        tick("R9", 32'h18, 32'h10, 0, 0);
        tick("R9", 32'h18, 32'h10, 0, 0);
        tick("R9", 32'h18, 32'h18, 0, 0);
        ev_sync = 1;
        tick("R6", 32'h1A, 32'h18, 0, 0);
        wr(32'h0, 1);
        tick("R9", 32'h18, 32'h0, 0, 0);
        // R11 interrupt gating
        ev_alarm_a = 1; irq_en = '0;
        tick("R11", 32'h100, 32'h100, 1, 0);
        irq_en = 9'h001;
        tick("R11", 32'h0, 32'h0, 1, 1);
        irq_en = 9'h002;
        tick("R11", 32'h0, 32'h0, 1, 0);
        ev_tamper = 3'b100; irq_en = 9'h100;
        tick("R11", 32'h0004_0000, 32'h0004_0000, 1, 1);
        wr(32'h0, 1); irq_en = 9'h1FF;
        tick("R11", 32'hFFFF_FFFF, 32'h0, 1, 0);
        repeat (2) @(negedge clk);
        if (q_m.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard left %0d items expected 0", q_m.size());
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule